// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block turns one parallel byte into an asynchronous serial character on a single transmit line. A mode byte selects the frame format: 5 to 8 data bits, no, even or odd parity, one, one-and-a-half or two stop bits, and a ratio of 1, 16 or 64 transmit-clock enables per bit. A command layer outside the block supplies a transmit-enable level and a break level. Bus decoding, synchronous operation and modem handshakes are handled elsewhere.

Software writes a byte into a one-entry holding register with a write strobe. When the shifter is idle and transmission is enabled, the held byte moves into the shifter on the next clock, and the character is sent least significant bit first. Two flags report the state of the transmit path. The ready flag shows that the holding register can take a byte. The empty flag shows that the shifter has nothing left to send. The mode is captured when a byte enters the shifter, so the format of a character in flight cannot change.

Top module: `async_char_tx`

## Requirements
- R1: With no character in flight, `txd_o` is 1. A character starts with one 0 start bit, then the data bits least significant bit first, then the parity bit if enabled, then stop bits at 1.
- R2: `mode_i[3:2]` sets the character length: 00=5, 01=6, 10=7, 11=8 data bits. Data bits above the length are not sent and do not affect parity.
- R3: `mode_i[5:4]` sets parity: `mode_i[4]`=0 means no parity bit, 01 means even, 11 means odd. Parity is computed over the data bits that are sent.
- R4: `mode_i[7:6]` sets the stop bits: 01 gives one, 11 gives two, and 00 is treated as one.
- R5: `mode_i[1:0]` sets the bit time: 01=1, 10=16, 11=64 enabled `tick_i` cycles, and 00 is treated as 1. Clocks without `tick_i` do not advance the character.
- R6: Stop code 10 gives one full stop bit and then a half-length stop bit at ratio 16 or 64. At ratio 1 it gives two full stop bits.
- R7: While `brk_i`=1, `txd_o` is 0. The character underneath keeps its timing.
- R8: `rdy_o` is 1 while the holding register is empty. It falls the clock after a write and rises the clock after the byte moves into the shifter.
- R9: `empty_o` is 1 while the shifter is idle. It falls on the clock that loads the shifter and rises on the clock that ends the final stop bit.
- R10: A byte moves into the shifter only while `tx_en_i`=1. A character already in flight finishes when `tx_en_i` drops.
- R11: A byte written during a character moves into the shifter on the clock after the final stop bit ends, so exactly one clock of idle line lies between the two characters.
- R12: The mode is sampled when the byte enters the shifter. A change to `mode_i` during a character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Transmit-clock enable, one per bit-time subdivision |
| mode_i | input | 8 | Frame format: stop[7:6], parity[5:4], length[3:2], ratio[1:0] |
| tx_en_i | input | 1 | Transmission allowed |
| brk_i | input | 1 | Force the line low |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial output line |
| rdy_o | output | 1 | Holding register empty |
| empty_o | output | 1 | Shifter idle |

## Verification
The assertions assume that the mode and enable inputs stay at legal two-state values and that a write does not arrive while the ready flag is low. Under that assumption, the holding register never loses a byte without notice. The stimulus writes only when the ready flag is high, except for the deliberate back-to-back case, where the first byte has already left the holding register. The stimulus also changes the mode only at the character boundary or after the shifter has taken its byte. Break is raised only while the line is idle or in the middle of a character, so the start-bit detection of the frame monitor is never confused.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef struct packed {
    logic [1:0] stop;
    logic [1:0] par;
    logic [1:0] len;
    logic [1:0] rate;
  } ctx_mode_t;
endpackage

// File: rtl/ctx_hold.sv
module ctx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (wr_i) data_o <= wdata_i;
      full_o <= wr_i | (full_o & ~take_i);
    end
  end

  // R8
  wr_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  // R10
  take_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_o);
endmodule

// File: rtl/ctx_framer.sv
module ctx_framer
  import ctx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int RMID = 16,
  parameter int RHI  = 64,
  localparam int FW  = DW + 4,
  localparam int BW  = $clog2(FW + 1),
  localparam int RW  = $clog2(RHI + 1)
) (
  input  ctx_mode_t       mode_i,
  input  logic [DW-1:0]   data_i,
  output logic [FW-1:0]   frame_o,
  output logic [BW-1:0]   nbits_o,
  output logic [RW-1:0]   ratio_o,
  output logic            half_o
);
  int   nd;
  int   stops;
  logic par_bit;

  always_comb begin
    nd      = DW - 3 + int'(mode_i.len);
    frame_o = '1;
    frame_o[0] = 1'b0;
    par_bit = mode_i.par[1];  // odd parity seeds with 1
    for (int i = 0; i < DW; i++) begin
      if (i < nd) begin
        frame_o[i+1] = data_i[i];
        par_bit      = par_bit ^ data_i[i];
      end
    end
    if (mode_i.par[0]) frame_o[nd+1] = par_bit;
    stops   = mode_i.stop[1] ? 2 : 1;
    nbits_o = BW'(1 + nd + int'(mode_i.par[0]) + stops);
  end

  always_comb begin
    case (mode_i.rate)
      2'b10:   ratio_o = RW'(RMID);
      2'b11:   ratio_o = RW'(RHI);
      default: ratio_o = RW'(1);
    endcase
    half_o = (mode_i.stop == 2'b10) && mode_i.rate[1];
  end
endmodule

// File: rtl/ctx_shifter.sv
module ctx_shifter #(
  parameter int FW = 12,
  parameter int BW = 4,
  parameter int RW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  input  logic [BW-1:0] nbits_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          half_i,
  output logic          busy_o,
  output logic          line_o
);
  logic [FW-1:0] sh_q;
  logic [BW-1:0] left_q;
  logic [RW-1:0] cnt_q, ratio_q, seg_len;
  logic          half_q, seg_end;

  always_comb begin
    seg_len = (left_q == BW'(1) && half_q) ? (ratio_q >> 1) : ratio_q;
    seg_end = tick_i && (cnt_q == seg_len - RW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      ratio_q <= RW'(1);
      half_q  <= 1'b0;
      busy_o  <= 1'b0;
    end else if (load_i) begin
      sh_q    <= frame_i;
      left_q  <= nbits_i;
      cnt_q   <= '0;
      ratio_q <= ratio_i;
      half_q  <= half_i;
      busy_o  <= 1'b1;
    end else if (busy_o && tick_i) begin
      if (seg_end) begin
        cnt_q  <= '0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - BW'(1);
        if (left_q == BW'(1)) busy_o <= 1'b0;
      end else begin
        cnt_q <= cnt_q + RW'(1);
      end
    end
  end

  assign line_o = busy_o ? sh_q[0] : 1'b1;

  // R11
  load_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  // R5
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < ratio_q);
  // R5
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(sh_q) && $stable(cnt_q) && busy_o));
  // R9
  busy_has_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> left_q != '0);
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import ctx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int RMID = 16,
  parameter int RHI  = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [7:0]    mode_i,
  input  logic          tx_en_i,
  input  logic          brk_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          txd_o,
  output logic          rdy_o,
  output logic          empty_o
);
  localparam int FW = DW + 4;
  localparam int BW = $clog2(FW + 1);
  localparam int RW = $clog2(RHI + 1);

  ctx_mode_t     mode_s;
  logic          full, busy, line, take;
  logic [DW-1:0] held;
  logic [FW-1:0] frame;
  logic [BW-1:0] nbits;
  logic [RW-1:0] ratio;
  logic          half;

  assign mode_s = ctx_mode_t'(mode_i);
  assign take   = full & ~busy & tx_en_i;

  ctx_hold #(.DW(DW)) i_hold (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .take_i(take), .full_o(full), .data_o(held)
  );

  ctx_framer #(.DW(DW), .RMID(RMID), .RHI(RHI)) i_framer (
    .mode_i(mode_s), .data_i(held), .frame_o(frame),
    .nbits_o(nbits), .ratio_o(ratio), .half_o(half)
  );

  ctx_shifter #(.FW(FW), .BW(BW), .RW(RW)) i_shifter (
    .clk_i, .rst_ni, .tick_i, .load_i(take), .frame_i(frame),
    .nbits_i(nbits), .ratio_i(ratio), .half_i(half),
    .busy_o(busy), .line_o(line)
  );

  assign txd_o   = ~brk_i & line;
  assign rdy_o   = ~full;
  assign empty_o = ~busy;

  // R1
  start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && !brk_i) |-> !txd_o);
  // R11
  pending_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !rdy_o && tx_en_i) |=> (!empty_o && rdy_o));
  // R10
  disabled_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !tx_en_i) |=> empty_o);
endmodule

// File: tb/test_async_char_tx.sv
module test_async_char_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [7:0] mode_i = 8'h4D;
  logic       tx_en_i = 1'b1;
  logic       brk_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       txd_o, rdy_o, empty_o;

  int checks = 0;
  int errors = 0;
  int tdiv   = 1;
  bit done   = 0;

  int    q_cnt[$];
  bit    q_lvl[$];
  string q_tag[$];

  async_char_tx i_async_char_tx (
    .clk_i(clk), .rst_ni, .tick_i, .mode_i, .tx_en_i, .brk_i,
    .wr_i, .wdata_i, .txd_o, .rdy_o, .empty_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected line level for every tick slot of one character
  task automatic push_frame(input logic [7:0] m, input logic [7:0] d, input string tag);
    int r, nd, cnt, ns;
    bit p;
    r   = (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
    nd  = 5 + int'(m[3:2]);
    cnt = 0;
    p   = m[5];
    repeat (r) q_lvl.push_back(1'b0);
    cnt += r;
    for (int i = 0; i < nd; i++) begin
      repeat (r) q_lvl.push_back(d[i]);
      cnt += r;
      p ^= d[i];
    end
    if (m[4]) begin
      repeat (r) q_lvl.push_back(p);
      cnt += r;
    end
    case (m[7:6])
      2'b11:   ns = 2 * r;
      2'b10:   ns = (r == 1) ? 2 : r + r / 2;
      default: ns = r;
    endcase
    repeat (ns) q_lvl.push_back(1'b1);
    cnt += ns;
    q_cnt.push_back(cnt);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [7:0] m, input logic [7:0] d, input string tag);
    @(negedge clk);
    mode_i = m;
    push_frame(m, d, tag);
    wr_i    = 1'b1;
    wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(empty_o && rdy_o && q_cnt.size() == 0));
    repeat (2) @(negedge clk);
  endtask

  // tick generator
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph     = (ph + 1) % tdiv;
      tick_i = (ph == 0);
    end
  end

  // monitor: one scoreboard check per character
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && !empty_o && txd_o === 1'b0 && !brk_i) begin
        int    n;
        bit    bad, e;
        string tag;
        if (q_cnt.size() == 0) begin
          chk(0, "R1 unexpected character", 1, 0);
        end else begin
          n   = q_cnt.pop_front();
          tag = q_tag.pop_front();
          bad = 0;
          for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            while (!tick_i) @(negedge clk);
            e = q_lvl.pop_front();
            if (!brk_i && txd_o !== e && !bad) begin
              bad = 1;
              $display("FAIL %s slot %0d actual %0d expected %0d", tag, k, txd_o, e);
            end
          end
          checks++;
          if (bad) errors++;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd_o === 1'b1, "R1 reset line", txd_o, 1);
    chk(rdy_o === 1'b1, "R8 reset ready", rdy_o, 1);
    chk(empty_o === 1'b1, "R9 reset empty", empty_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8 R9 flag timing from an idle shifter
    send(8'h4D, 8'hA5, "R1 8N1 x1");
    chk(rdy_o === 1'b0, "R8 ready after write", rdy_o, 0);
    chk(empty_o === 1'b1, "R9 empty before load", empty_o, 1);
    @(negedge clk);
    chk(rdy_o === 1'b1, "R8 ready after load", rdy_o, 1);
    chk(empty_o === 1'b0, "R9 busy after load", empty_o, 0);
    wait_idle();

    // R2 lengths, high bits ignored
    send(8'h41, 8'hE6, "R2 5 bits");     wait_idle();
    send(8'h45, 8'hDB, "R2 6 bits");     wait_idle();
    send(8'h49, 8'hB3, "R2 7 bits");     wait_idle();
    // R3 parity
    send(8'h59, 8'hC5, "R3 7 even");     wait_idle();
    send(8'h71, 8'hE3, "R3 5 odd");      wait_idle();
    send(8'h7D, 8'h00, "R3 8 odd zero"); wait_idle();
    send(8'h6D, 8'h01, "R3 D4 clear");   wait_idle();
    // R4 stops
    send(8'hCD, 8'h5A, "R4 two stops");  wait_idle();
    send(8'h0D, 8'h3C, "R4 code 00");    wait_idle();
    // R5 ratios and tick gating
    send(8'h4E, 8'h96, "R5 x16");        wait_idle();
    send(8'hDB, 8'h4B, "R5 x64 7E2");    wait_idle();
    send(8'h4C, 8'h81, "R5 code 00");    wait_idle();
    tdiv = 3;
    send(8'h4E, 8'h69, "R5 x16 gated");  wait_idle();
    send(8'h59, 8'h2A, "R5 x1 gated");   wait_idle();
    tdiv = 1;
    // R6 one and a half stops
    send(8'h8E, 8'hF0, "R6 x16");        wait_idle();
    send(8'hB3, 8'h15, "R6 x64");        wait_idle();
    send(8'h8D, 8'h0F, "R6 x1");         wait_idle();

    // R11 back to back
    send(8'h4D, 8'h33, "R11 first");
    send(8'h4D, 8'hCC, "R11 second");
    while (!empty_o) @(negedge clk);
    chk(txd_o === 1'b1, "R11 gap idle", txd_o, 1);
    @(negedge clk);
    chk(empty_o === 1'b0, "R11 next loaded", empty_o, 0);
    chk(txd_o === 1'b0, "R11 next start", txd_o, 0);
    wait_idle();

    // R10 enable gating
    tx_en_i = 1'b0;
    send(8'h4D, 8'h77, "R10 held byte");
    repeat (20) @(negedge clk);
    chk(empty_o === 1'b1, "R10 no load", empty_o, 1);
    chk(txd_o === 1'b1, "R10 line idle", txd_o, 1);
    chk(rdy_o === 1'b0, "R10 still held", rdy_o, 0);
    tx_en_i = 1'b1;
    wait_idle();
    send(8'h4E, 8'hA9, "R10 drop mid");
    repeat (30) @(negedge clk);
    tx_en_i = 1'b0;
    while (!empty_o) @(negedge clk);
    chk(q_cnt.size() == 0, "R10 finished", q_cnt.size(), 0);
    tx_en_i = 1'b1;
    wait_idle();

    // R7 break
    brk_i = 1'b1;
    @(negedge clk);
    chk(txd_o === 1'b0, "R7 idle break", txd_o, 0);
    brk_i = 1'b0;
    @(negedge clk);
    chk(txd_o === 1'b1, "R7 release", txd_o, 1);
    send(8'h4E, 8'hFF, "R7 timing kept");
    repeat (40) @(negedge clk);
    brk_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd_o === 1'b0, "R7 mid break", txd_o, 0);
    brk_i = 1'b0;
    wait_idle();

    // R12 mode captured at load
    send(8'h4E, 8'h5C, "R12 old mode");
    @(negedge clk);
    mode_i = 8'h41;
    wait_idle();
    mode_i = 8'h4D;
    send(8'h4D, 8'h18, "R12 new mode");
    wait_idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule